// File: doc/BRIEF.md
# Nine-Bit Asynchronous Receiver with Address Filter

This block receives asynchronous serial frames on a single line and delivers each byte to a small control/status register set. A frame is a low start bit, eight data bits sent least significant bit first, an extra ninth bit when one of the two 9-bit modes is selected, and a high stop bit. The line is sampled on a one-cycle enable that pulses sixteen times per bit period, so baud generation stays outside the block. Each bit is taken at the centre of its bit period.

For multi-drop links the receiver can filter frames by address in hardware. When the filter is on in a 9-bit mode, a frame is accepted only if its ninth bit is 1 and its byte equals the programmed station address. The usual flow is that software clears the filter after its own address arrives, reads the data frames that follow, and then sets the filter again. One bit of the control register is shared: a side-band select decides whether that bit is the upper mode bit or the sticky framing-error flag.

Top module: `uart9_rx_filter`

## Requirements
- R1: After reset the received byte, the ninth-bit field, the receive flag, the framing-error flag and all control fields read 0.
- R2: With the upper mode bit at 0 (8-bit modes), a frame has eight data bits. Bit 0 of the byte is received first. On completion the byte is stored, the sampled stop bit goes into the ninth-bit field, and the receive flag (control bit 0) is set.
- R3: With the upper mode bit at 1 (9-bit modes), the bit after the eight data bits is stored in the ninth-bit field (control bit 2, read-only), and the stop bit follows it.
- R4: A stop bit sampled as 0 sets the framing-error flag, and the frame is still delivered. The flag stays set through later good frames and is cleared only by a software write.
- R5: Control bit 7 is shared. With the select input at 0 it reads and writes the upper mode bit. With the select at 1 it reads and writes the framing-error flag, and the mode bit is left unchanged. The other control fields are: bit 6 lower mode bit, bit 5 filter enable, bit 4 receive enable, bit 0 receive flag.
- R6: With receive enable at 0, frames on the line leave every register and output unchanged.
- R7: In a 9-bit mode with the filter enabled, a frame is accepted only when its ninth bit is 1 and its byte equals the station address. A rejected frame leaves the byte, the ninth-bit field and the receive flag unchanged.
- R8: In a 9-bit mode with the filter off, every frame is accepted, including data frames whose ninth bit is 0.
- R9: In the 8-bit modes the filter enable has no effect.
- R10: A low pulse that has ended by the middle of the start bit is dropped. The receiver returns to idle and sets no flag.
- R11: After a frame whose stop bit was 0, the receiver does not look for a new start bit until the line has gone high.
- R12: Software clears the receive flag by writing 0 to control bit 0. If a frame completes in the same cycle, the completion takes priority.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, sixteen pulses per bit |
| rxd_in | input | 1 | Serial receive line, idle high |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| fe_view | input | 1 | Selects mode bit (0) or framing-error flag (1) on control bit 7 |
| own_addr | input | 8 | Station address used by the filter |
| ctl_rdata | output | 8 | Control register read value |
| rx_byte | output | 8 | Last accepted byte |
| rx_irq | output | 1 | Receive flag |
| frame_err | output | 1 | Framing-error flag |

## Verification
The bench sends rejected and accepted 9-bit frames side by side: frames with the right address but a ninth bit of 0, and frames with a ninth bit of 1 but the wrong address. A filter that compares only one of the two fields would then overwrite the byte or raise the flag. A bad stop bit is followed by a line held low for two more bit times. A receiver that re-arms at once would take that low level as a false frame of zeros. A framing-error flag that a good frame clears is also caught. Shared-bit writes with the select at 1 are checked against a 9-bit mode setting that must survive them, and a short start glitch must leave everything unchanged.

// File: rtl/uart9_rx_pkg.sv
package uart9_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_WAITHI
    } rx_state_e;

    localparam int unsigned CTL_SHARED = 7;
    localparam int unsigned CTL_MLO    = 6;
    localparam int unsigned CTL_FILT   = 5;
    localparam int unsigned CTL_EN     = 4;
    localparam int unsigned CTL_NINTH  = 2;
    localparam int unsigned CTL_RI     = 0;

endpackage

// File: rtl/uart9_sync.sv
module uart9_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign d_out = sh_q[STAGES-1];
endmodule

// File: rtl/uart9_frame_rx.sv
module uart9_frame_rx
    import uart9_rx_pkg::*;
#(
    parameter int unsigned OSR = 16,
    parameter int unsigned DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rx,
    input  logic          en,
    input  logic          nine,
    output logic          done,
    output logic [DW-1:0] f_byte,
    output logic          f_ninth,
    output logic          f_stop
);
    localparam int unsigned CW   = $clog2(OSR);
    localparam int unsigned IW   = $clog2(DW + 1) + 1;
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    typedef struct packed {
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic [DW-1:0] sh;
        logic          b9;
        logic          stp;
        logic          done;
    } fr_t;

    fr_t fr_d, fr_q;

    always_comb begin
        fr_d      = fr_q;
        fr_d.done = 1'b0;
        unique case (fr_q.st)
            ST_IDLE: begin
                if (tick && en && !rx) begin
                    fr_d.st  = ST_START;
                    fr_d.cnt = '0;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (fr_q.cnt == MID) begin
                        fr_d.cnt = '0;
                        fr_d.idx = '0;
                        fr_d.st  = rx ? ST_IDLE : ST_DATA;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (fr_q.cnt == LAST) begin
                        fr_d.cnt = '0;
                        if (fr_q.idx < IW'(DW)) fr_d.sh = {rx, fr_q.sh[DW-1:1]};
                        else                    fr_d.b9 = rx;
                        if ((fr_q.idx == IW'(DW - 1) && !nine) || fr_q.idx == IW'(DW))
                            fr_d.st = ST_STOP;
                        fr_d.idx = fr_q.idx + 1'b1;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (fr_q.cnt == LAST) begin
                        fr_d.stp  = rx;
                        fr_d.done = 1'b1;
                        fr_d.cnt  = '0;
                        fr_d.st   = rx ? ST_IDLE : ST_WAITHI;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
            end
            ST_WAITHI: begin
                if (rx) fr_d.st = ST_IDLE;
            end
            default: fr_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q    <= '0;
            fr_q.st <= ST_IDLE;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign done    = fr_q.done;
    assign f_byte  = fr_q.sh;
    assign f_ninth = fr_q.b9;
    assign f_stop  = fr_q.stp;

    // R3
    done_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.done |-> $past(fr_q.st) == ST_STOP);

    // R6
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.st == ST_IDLE && !en) |=> fr_q.st == ST_IDLE);

    // R11
    wait_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.st == ST_WAITHI && !rx) |=> fr_q.st == ST_WAITHI);
endmodule

// File: rtl/uart9_ctl_regs.sv
module uart9_ctl_regs
    import uart9_rx_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [7:0]    wdata,
    input  logic          fe_sel,
    input  logic [DW-1:0] own_addr,
    input  logic          done,
    input  logic [DW-1:0] f_byte,
    input  logic          f_ninth,
    input  logic          f_stop,
    output logic          nine_mode,
    output logic          rx_en,
    output logic          ri,
    output logic          fe,
    output logic [DW-1:0] data,
    output logic [7:0]    rdata
);
    typedef struct packed {
        logic          mhi;
        logic          mlo;
        logic          filt;
        logic          en;
        logic          ri;
        logic          fe;
        logic          ninth;
        logic [DW-1:0] data;
    } rg_t;

    rg_t  rg_d, rg_q;
    logic accept_w;
    logic unused_wbits;

    assign unused_wbits = ^{wdata[3:1]};

    always_comb begin
        accept_w = !(rg_q.mhi && rg_q.filt) || (f_ninth && (f_byte == own_addr));
        rg_d = rg_q;
        if (we) begin
            if (fe_sel) rg_d.fe  = wdata[CTL_SHARED];
            else        rg_d.mhi = wdata[CTL_SHARED];
            rg_d.mlo  = wdata[CTL_MLO];
            rg_d.filt = wdata[CTL_FILT];
            rg_d.en   = wdata[CTL_EN];
            rg_d.ri   = wdata[CTL_RI];
        end
        if (done) begin
            if (!f_stop) rg_d.fe = 1'b1;
            if (accept_w) begin
                rg_d.data  = f_byte;
                rg_d.ninth = rg_q.mhi ? f_ninth : f_stop;
                rg_d.ri    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        rdata             = '0;
        rdata[CTL_SHARED] = fe_sel ? rg_q.fe : rg_q.mhi;
        rdata[CTL_MLO]    = rg_q.mlo;
        rdata[CTL_FILT]   = rg_q.filt;
        rdata[CTL_EN]     = rg_q.en;
        rdata[CTL_NINTH]  = rg_q.ninth;
        rdata[CTL_RI]     = rg_q.ri;
    end

    assign nine_mode = rg_q.mhi;
    assign rx_en     = rg_q.en;
    assign ri        = rg_q.ri;
    assign fe        = rg_q.fe;
    assign data      = rg_q.data;

    // R7
    drop_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !accept_w) |=> ($stable(rg_q.data) && $stable(rg_q.ninth)));

    // R4
    fe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_q.fe && !(we && fe_sel && !wdata[CTL_SHARED])) |=> rg_q.fe);

    // R4
    fe_on_bad_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !f_stop) |=> rg_q.fe);

    // R12
    ri_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rg_q.ri) |-> $past(done || we));

    // R5
    mode_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && fe_sel) |=> $stable(rg_q.mhi));
endmodule

// File: rtl/uart9_rx_filter.sv
module uart9_rx_filter #(
    parameter int unsigned OSR         = 16,
    parameter int unsigned DW          = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          rxd_in,
    input  logic          ctl_we,
    input  logic [7:0]    ctl_wdata,
    input  logic          fe_view,
    input  logic [DW-1:0] own_addr,
    output logic [7:0]    ctl_rdata,
    output logic [DW-1:0] rx_byte,
    output logic          rx_irq,
    output logic          frame_err
);
    logic          rx_s;
    logic          done_w, ninth_w, stop_w, nine_w, en_w;
    logic [DW-1:0] byte_w;

    uart9_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_in(rxd_in), .d_out(rx_s)
    );

    uart9_frame_rx #(.OSR(OSR), .DW(DW)) frame_i (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(rx_s), .en(en_w),
        .nine(nine_w), .done(done_w), .f_byte(byte_w), .f_ninth(ninth_w),
        .f_stop(stop_w)
    );

    uart9_ctl_regs #(.DW(DW)) regs_i (
        .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
        .fe_sel(fe_view), .own_addr(own_addr), .done(done_w),
        .f_byte(byte_w), .f_ninth(ninth_w), .f_stop(stop_w),
        .nine_mode(nine_w), .rx_en(en_w), .ri(rx_irq), .fe(frame_err),
        .data(rx_byte), .rdata(ctl_rdata)
    );
endmodule

// File: tb/uart9_rx_filter_tb.sv
`timescale 1ns/1ps
module uart9_rx_filter_tb_top;
    localparam int BITCLK = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd_in = 1'b1;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       fe_view = 1'b0;
    logic [7:0] own_addr = 8'h42;
    logic [7:0] ctl_rdata, rx_byte;
    logic       rx_irq, frame_err;

    int    n_cmp = 0, n_bad = 0;
    bit    chk_en = 1'b0;
    bit    done_flag = 1'b0;
    string cur_req = "R1";
    int    tdiv = 0;

    // reference state
    bit       e_mhi, e_mlo, e_filt, e_en, e_ri, e_fe, e_ninth;
    bit [7:0] e_data;

    always #2.5 clk = ~clk;

    uart9_rx_filter dut_i (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd_in(rxd_in),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .fe_view(fe_view),
        .own_addr(own_addr), .ctl_rdata(ctl_rdata), .rx_byte(rx_byte),
        .rx_irq(rx_irq), .frame_err(frame_err)
    );

    always @(posedge clk) begin
        tdiv    <= (tdiv + 1) % 4;
        os_tick <= (tdiv == 3);
    end

    function automatic bit [7:0] exp_rd();
        return {fe_view ? e_fe : e_mhi, e_mlo, e_filt, e_en, 1'b0, e_ninth, 1'b0, e_ri};
    endfunction

    task automatic cmp(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en && !done_flag) begin
            cmp(cur_req, "rx_byte", rx_byte, e_data);
            cmp(cur_req, "rx_irq", rx_irq, e_ri);
            cmp(cur_req, "frame_err", frame_err, e_fe);
            cmp(cur_req, "ctl_rdata", ctl_rdata, exp_rd());
        end
    end

    task automatic wr(bit [7:0] d);
        @(posedge clk); #1;
        ctl_we = 1'b1; ctl_wdata = d;
        @(posedge clk); #1;
        ctl_we = 1'b0;
        if (fe_view) e_fe = d[7]; else e_mhi = d[7];
        e_mlo = d[6]; e_filt = d[5]; e_en = d[4]; e_ri = d[0];
    endtask

    task automatic set_sel(bit s);
        @(posedge clk); #1;
        fe_view = s;
    endtask

    // frame outcome from the requirements
    task automatic model_frame(bit [7:0] b, bit n9, bit stp);
        bit acc;
        if (!e_en) return;
        if (!stp) e_fe = 1'b1;
        acc = !(e_mhi && e_filt) || (n9 && b == own_addr);
        if (acc) begin
            e_data  = b;
            e_ninth = e_mhi ? n9 : stp;
            e_ri    = 1'b1;
        end
    endtask

    task automatic send(bit [7:0] b, bit n9, bit stp, int hold_bits);
        bit nine;
        nine = e_mhi;
        @(posedge clk); #1;
        rxd_in = 1'b0;
        repeat (BITCLK) @(posedge clk);
        for (int i = 0; i < 8; i++) begin
            #1 rxd_in = b[i];
            repeat (BITCLK) @(posedge clk);
        end
        if (nine) begin
            #1 rxd_in = n9;
            repeat (BITCLK) @(posedge clk);
        end
        #1 rxd_in = stp;
        chk_en = 1'b0;
        repeat (BITCLK) @(posedge clk);
        #1 model_frame(b, n9, stp);
        chk_en = 1'b1;
        repeat (hold_bits * BITCLK) @(posedge clk);
        #1 rxd_in = 1'b1;
        repeat (BITCLK) @(posedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        e_mhi = 0; e_mlo = 0; e_filt = 0; e_en = 0; e_ri = 0; e_fe = 0; e_ninth = 0; e_data = 0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        cmp("R1", "reset rdata", ctl_rdata, 0);
        cmp("R1", "reset byte", rx_byte, 0);
        cmp("R1", "reset flags", {rx_irq, frame_err}, 0);
        chk_en = 1'b1;

        cur_req = "R2"; wr(8'h10);
        send(8'hA5, 1'b0, 1'b1, 0);
        cur_req = "R12"; wr(8'h10);
        cur_req = "R2"; send(8'h3C, 1'b0, 1'b1, 0);

        cur_req = "R6"; wr(8'h00);
        send(8'h77, 1'b0, 1'b1, 0);

        cur_req = "R9"; wr(8'h30);
        send(8'h11, 1'b0, 1'b1, 0);

        cur_req = "R3"; wr(8'hD0);
        send(8'h5A, 1'b0, 1'b1, 0);
        send(8'hC3, 1'b1, 1'b1, 0);

        cur_req = "R7"; wr(8'hF0);
        send(8'h42, 1'b0, 1'b1, 0);
        send(8'h41, 1'b1, 1'b1, 0);
        wr(8'hF0);
        send(8'h42, 1'b1, 1'b1, 0);

        cur_req = "R8"; wr(8'hD0);
        send(8'h99, 1'b0, 1'b1, 0);
        cur_req = "R7"; wr(8'hF0);
        send(8'h66, 1'b0, 1'b1, 0);

        cur_req = "R4"; wr(8'h10);
        send(8'h81, 1'b0, 1'b0, 0);
        send(8'h22, 1'b0, 1'b1, 0);

        cur_req = "R5"; set_sel(1'b1);
        wr(8'h10);
        wr(8'h90);
        set_sel(1'b0);
        wr(8'hD0);
        set_sel(1'b1);
        wr(8'h50);
        set_sel(1'b0);
        send(8'hE7, 1'b1, 1'b1, 0);

        cur_req = "R11"; wr(8'h10);
        send(8'h00, 1'b0, 1'b0, 2);
        send(8'h6B, 1'b0, 1'b1, 0);

        cur_req = "R10"; wr(8'h10);
        @(posedge clk); #1 rxd_in = 1'b0;
        repeat (12) @(posedge clk);
        #1 rxd_in = 1'b1;
        repeat (3 * BITCLK) @(posedge clk);

        @(negedge clk);
        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule